// File: doc/BRIEF.md
# SPI Master Controller with Transmit and Receive FIFOs

This block is a bus-attached serial port that acts as the master on an SPI link. Software reaches it through a small 32-bit register bus. The bus has an address, a write strobe, a read strobe, write data and combinational read data. Words written to the data location wait in an eight-entry transmit queue. Each queued word becomes one serial frame of 4 to 16 bits, sent most significant bit first on `mosi`. During the same frame a word of the same length is shifted in from `miso`, and that word is stored in an eight-entry receive queue. Clock polarity, clock phase, frame length and the serial clock rate can all be programmed. `fss_n` is held low for the length of each frame.

Three level interrupts are provided: receive queue at least half full, transmit queue at most half full, and receive overrun. An internal loopback routes the transmitted bit stream back into the receiver, so the data path can be exercised with no device attached. Software gates the serial engine with an enable bit. While the engine is stopped, the transmit queue still accepts words.

Register offsets: 0x00 frame control, 0x04 port control, 0x08 data, 0x0C status, 0x10 clock prescale, 0x14 interrupt identify (any write to 0x14 clears the overrun).

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, status reads 0x03, `sck` is 0, `fss_n` is 1, all three interrupts are low, and the frame control register reads 0.
- R2: The frame control register (0x00) keeps all 16 written bits. Port control (0x04) keeps bits 4:0 only, so bits 5 and 6 read as zero. Prescale (0x10) keeps bits 7:1, and bit 0 reads as zero.
- R3: Frame control field layout: size code in bits 3:0, polarity in bit 6, phase in bit 7, rate divider SCR in bits 15:8. A frame has size code + 1 bits. Codes below 3 give a 4-bit frame. Bits go out most significant first on `mosi`. `fss_n` is low for exactly 2·N·H clock cycles, where H = max(prescale/2, 1)·(SCR+1). When no frame is running, `sck` rests at the polarity level.
- R4: With phase 0, data is sampled on the leading `sck` edge of each bit and changed on the trailing edge. With phase 1, data is changed on the leading edge and sampled on the trailing edge. Both polarities work with both phases.
- R5: A received frame reads back right-justified from 0x08, with the bits above the frame length at zero. Each read of 0x08 removes one entry. A read with the queue empty returns 0.
- R6: When port control bit 3 (loopback) is set, the receiver takes its bits from the transmit output and ignores `miso`.
- R7: Each queue holds 8 frames. A write to 0x08 while the transmit queue is full is dropped. Status bit layout: 0 transmit empty, 1 transmit not full, 2 receive not empty, 3 receive full, 4 busy.
- R8: If a frame completes while the receive queue is full and no read of 0x08 happens in that cycle, the frame is discarded and the overrun flag is set. A read in the same cycle makes room, so the frame is stored and no overrun occurs. The flag stays set until any write to 0x14.
- R9: Each interrupt output is its level condition ANDed with its enable: receive with bit 0 of 0x04, transmit with bit 1, overrun with bit 2. The receive condition is 4 or more entries in the receive queue; the transmit condition is 4 or fewer in the transmit queue. 0x14 reads these as bit 0 receive, bit 1 transmit, bit 2 overrun.
- R10: While port control bit 4 (enable) is clear, no frame starts, any running frame stops, `fss_n` stays 1, `sck` stays at the polarity level, and writes to 0x08 still fill the transmit queue.
- R11: Status bit 4 (busy) is 1 whenever a frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at 0x08) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| fss_n | output | 1 | Frame select, active low |
| irq_rx | output | 1 | Receive level interrupt |
| irq_tx | output | 1 | Transmit level interrupt |
| irq_ovr | output | 1 | Receive overrun interrupt |

## Verification
Two events can land on the same clock edge: the last `sck` edge of a frame, which stores the received word, and a bus read of the data register, which frees an entry. The bench first fills the receive queue to eight entries in loopback, using the fastest clock setting (one cycle per half period). It then sends one more word and counts clocks from the falling edge of `fss_n`, so that its read strobe meets the final edge exactly. The test passes only if the overrun flag stays clear and the ninth word appears last when the queue is drained. A separate run without the read checks the case where the frame is dropped and the flag is raised.

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int DEPTH = 8,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          sck,
  output logic          mosi,
  input  logic          miso,
  output logic          fss_n,
  output logic          irq_rx,
  output logic          irq_tx,
  output logic          irq_ovr
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);
  localparam logic [CW-1:0] HALFC = CW'(DEPTH / 2);
  localparam logic [AW-1:0] A_C0  = AW'(8'h00);
  localparam logic [AW-1:0] A_C1  = AW'(8'h04);
  localparam logic [AW-1:0] A_DAT = AW'(8'h08);
  localparam logic [AW-1:0] A_ST  = AW'(8'h0C);
  localparam logic [AW-1:0] A_PS  = AW'(8'h10);
  localparam logic [AW-1:0] A_IC  = AW'(8'h14);

  logic [15:0]   cfg0;
  logic [4:0]    cfg1;
  logic [7:1]    presc;
  logic          ovr;
  logic [15:0]   tx_mem [DEPTH];
  logic [15:0]   rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          act, sck_r, mosi_r;
  logic [15:0]   div, tx_sh, rx_sh;
  logic [5:0]    edg;

  wire pol    = cfg0[6];
  wire pha    = cfg0[7];
  wire ie_rx  = cfg1[0];
  wire ie_tx  = cfg1[1];
  wire ie_ovr = cfg1[2];
  wire lbk    = cfg1[3];
  wire en     = cfg1[4];

  wire [3:0]  sz     = (cfg0[3:0] < 4'd3) ? 4'd3 : cfg0[3:0];
  wire [15:0] mask   = 16'hFFFF >> (4'd15 - sz);
  wire [6:0]  ph     = (presc == 7'd0) ? 7'd1 : presc;
  wire [8:0]  scr_p1 = {1'b0, cfg0[15:8]} + 9'd1;
  wire [15:0] half   = {9'd0, ph} * {7'd0, scr_p1};
  wire [5:0]  last_e = {1'b0, sz, 1'b1};

  wire sel_c0  = bus_addr == A_C0;
  wire sel_c1  = bus_addr == A_C1;
  wire sel_dat = bus_addr == A_DAT;
  wire sel_ps  = bus_addr == A_PS;
  wire sel_ic  = bus_addr == A_IC;

  wire start = !act && en && (tx_cnt != '0);
  wire tick  = act && en && (div == half - 16'd1);
  wire samp  = (!edg[0]) ^ pha;
  wire done  = tick && (edg == last_e);
  wire din   = lbk ? mosi_r : miso;
  wire [15:0] rx_nx   = {rx_sh[14:0], din};
  wire [15:0] rx_word = (samp ? rx_nx : rx_sh) & mask;
  wire [15:0] tx_aln  = tx_mem[tx_rp] << (4'd15 - sz);

  wire tx_push = bus_wr && sel_dat && (tx_cnt != FULLC);
  wire rx_pop  = bus_rd && sel_dat && (rx_cnt != '0);
  wire rx_room = (rx_cnt != FULLC) || rx_pop;
  wire rx_push = done && rx_room;
  wire ovr_set = done && !rx_room;
  wire ic_wr   = bus_wr && sel_ic;

  wire unused_wdata = &{1'b0, bus_wdata[31:16]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg0  <= '0;
      cfg1  <= '0;
      presc <= '0;
    end else if (bus_wr) begin
      if (sel_c0) cfg0  <= bus_wdata[15:0];
      if (sel_c1) cfg1  <= bus_wdata[4:0];
      if (sel_ps) presc <= bus_wdata[7:1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ovr <= 1'b0;
    else        ovr <= ovr_set || (ovr && !ic_wr);

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[15:0];

  always_ff @(posedge clk)
    if (rx_push) rx_mem[rx_wp] <= rx_word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + PW'(1);
      if (start)   tx_rp <= tx_rp + PW'(1);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(start);
      if (rx_push) rx_wp <= rx_wp + PW'(1);
      if (rx_pop)  rx_rp <= rx_rp + PW'(1);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act    <= 1'b0;
      sck_r  <= 1'b0;
      mosi_r <= 1'b0;
      div    <= '0;
      edg    <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else if (start) begin
      act   <= 1'b1;
      sck_r <= pol;
      div   <= '0;
      edg   <= '0;
      rx_sh <= '0;
      if (pha) begin
        tx_sh <= tx_aln;
      end else begin
        mosi_r <= tx_aln[15];
        tx_sh  <= {tx_aln[14:0], 1'b0};
      end
    end else if (act) begin
      if (!en) begin
        act <= 1'b0;
      end else if (tick) begin
        div   <= '0;
        sck_r <= !sck_r;
        edg   <= edg + 6'd1;
        if (samp) begin
          rx_sh <= rx_nx;
        end else begin
          mosi_r <= tx_sh[15];
          tx_sh  <= {tx_sh[14:0], 1'b0};
        end
        if (done) act <= 1'b0;
      end else begin
        div <= div + 16'd1;
      end
    end

  assign sck     = act ? sck_r : pol;
  assign mosi    = mosi_r;
  assign fss_n   = !act;
  assign irq_rx  = ie_rx && (rx_cnt >= HALFC);
  assign irq_tx  = ie_tx && (tx_cnt <= HALFC);
  assign irq_ovr = ie_ovr && ovr;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_C0:    bus_rdata = {16'd0, cfg0};
      A_C1:    bus_rdata = {27'd0, cfg1};
      A_DAT:   bus_rdata = (rx_cnt != '0) ? {16'd0, rx_mem[rx_rp]} : 32'd0;
      A_ST:    bus_rdata = {27'd0, act, rx_cnt == FULLC, rx_cnt != '0,
                            tx_cnt != FULLC, tx_cnt == '0};
      A_PS:    bus_rdata = {24'd0, presc, 1'b0};
      A_IC:    bus_rdata = {29'd0, irq_ovr, irq_tx, irq_rx};
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [AW-1:0]            bus_addr,
  input logic                     bus_wr,
  input logic                     bus_rd,
  input logic                     fss_n,
  input logic                     irq_rx,
  input logic                     irq_tx,
  input logic                     en,
  input logic                     ovr,
  input logic [$clog2(DEPTH):0]   tx_cnt,
  input logic [$clog2(DEPTH):0]   rx_cnt
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);
  localparam logic [CW-1:0] HALFC = CW'(DEPTH / 2);
  localparam logic [AW-1:0] A_DAT = AW'(8'h08);
  localparam logic [AW-1:0] A_IC  = AW'(8'h14);

  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !(bus_wr && bus_addr == A_IC)) |=> ovr);

  a_r8_ovr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_IC && fss_n) |=> !ovr);

  a_r5_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_DAT && rx_cnt != '0 && fss_n)
      |=> (rx_cnt == $past(rx_cnt) - CW'(1)));

  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == FULLC && !en) |=> (tx_cnt == FULLC));

  a_r7_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == FULLC && !(bus_rd && bus_addr == A_DAT)) |=> (rx_cnt == FULLC));

  a_r10_off_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> fss_n);

  a_r9_tx_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |-> (tx_cnt <= HALFC));

  a_r9_rx_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> (rx_cnt >= HALFC));
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .fss_n    (fss_n),
  .irq_rx   (irq_rx),
  .irq_tx   (irq_tx),
  .en       (cfg1[4]),
  .ovr      (ovr),
  .tx_cnt   (tx_cnt),
  .rx_cnt   (rx_cnt)
);

// File: tb/spi_fifo_master_bench.sv
module spi_fifo_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sck, mosi, fss_n, irq_rx, irq_tx, irq_ovr;
  logic        miso = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_fifo_master u_spi_fifo_master (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .fss_n(fss_n),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_ovr(irq_ovr));

  logic [15:0] s_pat = '0, s_cap = '0;
  int  s_n = 8, s_idx = 0, s_smp = 99;
  logic s_pha = 1'b0, s_pol = 1'b0, s_lf = 1'b1, s_ls = 1'b0;

  always @(fss_n or sck) begin
    if (fss_n !== s_lf) begin
      s_lf = fss_n;
      if (fss_n === 1'b0) begin
        s_idx = 0; s_smp = 0; s_cap = '0;
        if (!s_pha) begin miso = s_pat[s_n-1]; s_idx = 1; end
      end
    end
    if (sck !== s_ls) begin
      s_ls = sck;
      if (s_smp < s_n) begin
        if ((sck != s_pol) ^ s_pha) begin
          s_cap = {s_cap[14:0], mosi};
          s_smp++;
        end else begin
          if (s_idx < s_n) miso = s_pat[s_n-1-s_idx];
          s_idx++;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_status(input logic [31:0] exp);
    logic [31:0] s;
    rd(5'h0C, s);
    for (int i = 0; i < 3000 && s != exp; i++) rd(5'h0C, s);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 sck", {31'd0, sck}, 0);
    chk("R1 fss_n", {31'd0, fss_n}, 1);
    chk("R1 irqs", {29'd0, irq_ovr, irq_tx, irq_rx}, 0);
    rd(5'h0C, d); chk("R1 status", d, 32'h03);
    rd(5'h00, d); chk("R1 frame control", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(5'h00, 32'hFFFF_ABC7); rd(5'h00, d); chk("R2 frame control", d, 32'hABC7);
    wr(5'h04, 32'h0000_006F); rd(5'h04, d); chk("R2 port control", d, 32'h0F);
    wr(5'h04, 32'h0);
    wr(5'h10, 32'h0000_00FF); rd(5'h10, d); chk("R2 prescale", d, 32'hFE);
    wr(5'h00, 32'h0);
  endtask

  task automatic run_frame(input string tag, input logic [3:0] code, input int n,
                           input bit pol, input bit pha, input int cps, input int scr,
                           input bit lbk, input logic [15:0] tw, input logic [15:0] pat);
    logic [31:0] d;
    int cnt, h;
    logic [15:0] m;
    s_pat = pat; s_n = n; s_pha = pha; s_pol = pol;
    wr(5'h04, 32'h0);
    wr(5'h10, cps);
    wr(5'h00, {16'd0, scr[7:0], pha, pol, 2'b00, code});
    wr(5'h04, 32'h10 | (32'(lbk) << 3));
    chk({tag, " R3 idle sck level"}, {31'd0, sck}, {31'd0, pol});
    wr(5'h08, {16'd0, tw});
    while (fss_n) @(negedge clk);
    cnt = 0;
    while (!fss_n) begin cnt++; @(negedge clk); end
    h = ((cps / 2) < 1 ? 1 : cps / 2) * (scr + 1);
    m = 16'((32'd1 << n) - 1);
    chk({tag, " R3 frame length"}, cnt, 2 * n * h);
    chk({tag, " R3 R4 mosi msb first"}, {16'd0, s_cap}, {16'd0, tw & m});
    rd(5'h08, d);
    if (lbk) chk({tag, " R6 loopback data"}, d, {16'd0, tw & m});
    else     chk({tag, " R4 R5 received data"}, d, {16'd0, pat & m});
  endtask

  task automatic t_fifo();
    logic [31:0] d;
    s_pol = 0; s_pha = 0; s_n = 8; s_pat = 0;
    wr(5'h04, 32'h0); wr(5'h10, 32'd2); wr(5'h00, 32'h0007);
    for (int i = 0; i < 9; i++) wr(5'h08, 32'hA0 + i);
    rd(5'h0C, d); chk("R7 tx full status", d, 32'h00);
    repeat (5) @(negedge clk);
    chk("R10 disabled fss_n", {31'd0, fss_n}, 1);
    chk("R10 disabled sck", {31'd0, sck}, 0);
    chk("R9 tx irq full", {31'd0, irq_tx}, 0);
    wr(5'h04, 32'h1F);
    rd(5'h0C, d); chk("R11 busy", d, 32'h12);
    wait_status(32'h0F);
    rd(5'h0C, d); chk("R7 rx full status", d, 32'h0F);
    chk("R9 irq levels", {30'd0, irq_tx, irq_rx}, 32'h3);
    rd(5'h14, d); chk("R9 identify", d, 32'h3);
    for (int i = 0; i < 8; i++) begin
      rd(5'h08, d); chk("R7 fifo order", d, 32'hA0 + i);
      if (i == 4) chk("R9 rx irq below half", {31'd0, irq_rx}, 0);
    end
    rd(5'h0C, d); chk("R5 drained status", d, 32'h03);
    rd(5'h08, d); chk("R5 empty read", d, 0);
  endtask

  task automatic fill_rx(input logic [31:0] base);
    wr(5'h04, 32'h0);
    for (int i = 0; i < 8; i++) wr(5'h08, base + i);
    wr(5'h04, 32'h1C);
    wait_status(32'h0F);
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    wr(5'h10, 32'd2); wr(5'h00, 32'h0007);
    fill_rx(32'h30);
    rd(5'h14, d); chk("R8 no overrun yet", d, 0);
    wr(5'h08, 32'h5A);
    while (fss_n) @(negedge clk);
    while (!fss_n) @(negedge clk);
    chk("R8 overrun irq", {31'd0, irq_ovr}, 1);
    rd(5'h14, d); chk("R8 overrun identify", d, 32'h4);
    for (int i = 0; i < 8; i++) begin
      rd(5'h08, d); chk("R8 kept data", d, 32'h30 + i);
    end
    rd(5'h08, d); chk("R8 dropped frame absent", d, 0);
    chk("R8 flag sticky", {31'd0, irq_ovr}, 1);
    wr(5'h14, 32'h0);
    chk("R8 cleared by write", {31'd0, irq_ovr}, 0);

    fill_rx(32'h40);
    wr(5'h08, 32'hC3);
    while (fss_n) @(negedge clk);
    repeat (15) @(negedge clk);
    bus_addr = 5'h08; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R8 same-cycle pop data", d, 32'h40);
    @(negedge clk);
    chk("R8 same-cycle no overrun", {31'd0, irq_ovr}, 0);
    for (int i = 1; i < 8; i++) begin
      rd(5'h08, d); chk("R8 same-cycle order", d, 32'h40 + i);
    end
    rd(5'h08, d); chk("R8 same-cycle frame stored", d, 32'hC3);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    run_frame("m0",   4'd7,  8,  0, 0, 2, 0, 0, 16'h00A5, 16'h003C);
    run_frame("m3",   4'd15, 16, 1, 1, 4, 2, 0, 16'hB29D, 16'h4E71);
    run_frame("m1",   4'd3,  4,  0, 1, 2, 1, 0, 16'h0009, 16'h0006);
    run_frame("m2",   4'd11, 12, 1, 0, 6, 0, 0, 16'h0ACE, 16'h0531);
    run_frame("clamp",4'd1,  4,  0, 0, 0, 0, 0, 16'h000B, 16'h000D);
    run_frame("lbk",  4'd9,  10, 0, 1, 2, 0, 1, 16'h0263, 16'h0000);
    t_fifo();
    t_overrun();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule